// File: doc/BRIEF.md
# SD Host Initialization Sequencer

This block is the host-side state machine that takes a single SD-protocol memory device from power-up to the stand-by state. It works through a command-issue interface toward a separate command/response serializer. For each command it presents an index, a 32-bit argument and the kind of response to expect. It then waits for the serializer to report one of two outcomes: a response, whose payload may carry a CRC-error flag, or a timeout. The block also owns the card clock enable and the choice between the slow identification clock and the fast transfer clock.

A `start` pulse begins the sequence, in this order:
1. A quiet clock preamble.
2. A software reset.
3. An interface-condition probe whose outcome sets the capacity-support bit of the operating-condition request.
4. A polled operating-condition loop, each request prefixed by an application-command escape.
5. Identification: the 128-bit identity is read and a relative address is requested.

The block finishes with `done`, or with `error` after it has returned to idle. The results are the identity, the relative address and a high-capacity flag. The poll budget comes from the `poll_limit` input. A parameter shortens the preamble for simulation.

Top module: `sd_init_seq`

## Requirements
- R1: After reset, `cmd_req`, `clk_en`, `clk_fast`, `done`, `error` and `high_cap` are 0, and `cid` and `rca` are all zeros.
- R2: After `start`, exactly `PREAMBLE_CLKS` cycles pass with `clk_en`=1 and no request. The first request follows at once: index 0, argument 0, response kind 0 (none).
- R3: The next request is index 8, argument 0x000001AA, response kind 1 (short). Three outcomes are possible:
  - A response with no CRC error whose bits [11:0] equal 0x1AA marks the device as answering.
  - A timeout marks the device as not answering.
  - Any other response raises `error`.
- R4: Every index-41 request is immediately preceded by an index-55 request. That index-55 request has argument 0 and kind 1.
- R5: The index-41 argument is 0x00FF8000, with bit 30 also set when the index-8 probe was answered. The index-41 request has kind 1.
- R6: While bit 31 of the index-41 response body is 0, the pair 55/41 is reissued and no other index is sent. The CRC-error flag is ignored on index-41 responses.
- R7: `high_cap` is set to bit 30 of the first index-41 response with bit 31 = 1, ANDed with the probe-answered condition.
- R8: The sequence aborts, sets `error`, clears `clk_en` and sends nothing more in two cases:
  - `poll_limit` busy index-41 responses have been received (a limit of 0 behaves as 1).
  - An index-55 or index-41 request times out, or an index-55 response has a CRC error.
- R9: Index 2 is sent with argument 0 and kind 2 (long). The 128-bit response with no CRC error is stored in `cid`. Index 3 is then sent with argument 0 and kind 1, and bits [31:16] of its response are stored in `rca`.
- R10: A timeout or a CRC error on index 2 or index 3 reissues the same command once. A second failure on that command sets `error` and returns to idle with `clk_en`=0.
- R11: `clk_fast` stays 0 through every request, including index 3. It rises in the same cycle as `done` after index 3 succeeds. `clk_en` stays 1 while `done` is set.
- R12: A `start` while idle or done restarts the sequence. The same cycle clears `done`, `error`, `high_cap`, `clk_fast`, `cid` and `rca`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin or restart the sequence |
| poll_limit | input | POLL_W | Maximum busy index-41 responses tolerated |
| cmd_req | output | 1 | One-cycle strobe to issue a command |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp_kind | output | 2 | Expected response: 0 none, 1 short, 2 long |
| rsp_valid | input | 1 | Response (or send completion for kind 0) received |
| rsp_timeout | input | 1 | No response arrived |
| rsp_crc_err | input | 1 | CRC error on the response, qualified by `rsp_valid` |
| rsp_data | input | 128 | Response body: [31:0] for short, [127:0] for long |
| clk_en | output | 1 | Card clock enable |
| clk_fast | output | 1 | 1 selects the fast transfer clock |
| done | output | 1 | Device reached stand-by |
| error | output | 1 | Sequence aborted |
| high_cap | output | 1 | Device reports high capacity |
| cid | output | 128 | Captured identity register |
| rca | output | 16 | Assigned relative address |

## Verification
The bench counts the exact length of the quiet preamble, so an off-by-one counter shows up as a miscount. It runs the capacity negotiation both ways:
- A probe that times out must clear the capacity-support bit and force `high_cap` low, even when the device reports bit 30 set.
- A design that latched bit 30 from a busy response, or ignored the probe outcome, would report the wrong capacity.

Busy responses carrying a CRC flag check that the block does not abort on a response type that has no CRC. One CRC failure and one timeout on the identification commands must be retried exactly once, and a second failure must abort. A design that aborted at once, or retried forever, is caught by the command stream. A finite poll budget must stop the loop after exactly the set number of busy replies.

// File: rtl/sd_init_seq.sv
module sd_init_seq #(
  parameter int PREAMBLE_CLKS = 74,
  parameter int POLL_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              cmd_req,
  output logic [5:0]        cmd_idx,
  output logic [31:0]       cmd_arg,
  output logic [1:0]        cmd_rsp_kind,
  input  logic              rsp_valid,
  input  logic              rsp_timeout,
  input  logic              rsp_crc_err,
  input  logic [127:0]      rsp_data,
  output logic              clk_en,
  output logic              clk_fast,
  output logic              done,
  output logic              error,
  output logic              high_cap,
  output logic [127:0]      cid,
  output logic [15:0]       rca
);

  localparam int CW = $clog2(PREAMBLE_CLKS + 1);
  localparam logic [31:0] PROBE_ARG = 32'h0000_01AA;
  localparam logic [31:0] VOLT_WIN  = 32'h00FF_8000;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_RST, S_PROBE, S_APP, S_OPC, S_IDENT, S_ADDR, S_DONE
  } state_t;

  state_t          state;
  logic [CW-1:0]   pre_cnt;
  logic [POLL_W-1:0] polls;
  logic            busy, answered, retried;

  wire issuing = (state == S_RST) || (state == S_PROBE) || (state == S_APP) ||
                 (state == S_OPC) || (state == S_IDENT) || (state == S_ADDR);
  wire fin     = busy && (rsp_valid || rsp_timeout);
  wire good    = rsp_valid && !rsp_crc_err && !rsp_timeout;
  wire over    = ({1'b0, polls} + 1'b1) >= {1'b0, poll_limit};
  wire restart = start && (state == S_IDLE || state == S_DONE);

  assign cmd_req = issuing && !busy;

  always_comb begin
    cmd_idx      = 6'd0;
    cmd_arg      = 32'h0;
    cmd_rsp_kind = 2'd0;
    case (state)
      S_PROBE: begin cmd_idx = 6'd8;  cmd_arg = PROBE_ARG; cmd_rsp_kind = 2'd1; end
      S_APP:   begin cmd_idx = 6'd55; cmd_rsp_kind = 2'd1; end
      S_OPC:   begin
        cmd_idx = 6'd41; cmd_rsp_kind = 2'd1;
        cmd_arg = VOLT_WIN | {1'b0, answered, 30'h0};
      end
      S_IDENT: begin cmd_idx = 6'd2;  cmd_rsp_kind = 2'd2; end
      S_ADDR:  begin cmd_idx = 6'd3;  cmd_rsp_kind = 2'd1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; pre_cnt <= '0; polls <= '0;
      busy <= 1'b0; answered <= 1'b0; retried <= 1'b0;
      clk_en <= 1'b0; clk_fast <= 1'b0; done <= 1'b0; error <= 1'b0;
      high_cap <= 1'b0; cid <= '0; rca <= '0;
    end else if (restart) begin
      state <= S_PRE; pre_cnt <= '0; polls <= '0;
      busy <= 1'b0; answered <= 1'b0; retried <= 1'b0;
      clk_en <= 1'b1; clk_fast <= 1'b0; done <= 1'b0; error <= 1'b0;
      high_cap <= 1'b0; cid <= '0; rca <= '0;
    end else if (state == S_PRE) begin
      if (pre_cnt == CW'(PREAMBLE_CLKS - 1)) state <= S_RST;
      else pre_cnt <= pre_cnt + 1'b1;
    end else if (cmd_req) begin
      busy <= 1'b1;
    end else if (fin) begin
      busy <= 1'b0;
      case (state)
        S_RST: state <= S_PROBE;
        S_PROBE: begin
          if (rsp_timeout) begin
            answered <= 1'b0; state <= S_APP;
          end else if (good && rsp_data[11:0] == PROBE_ARG[11:0]) begin
            answered <= 1'b1; state <= S_APP;
          end else begin
            state <= S_IDLE; error <= 1'b1; clk_en <= 1'b0;
          end
        end
        S_APP: begin
          if (good) state <= S_OPC;
          else begin state <= S_IDLE; error <= 1'b1; clk_en <= 1'b0; end
        end
        S_OPC: begin
          if (rsp_timeout) begin
            state <= S_IDLE; error <= 1'b1; clk_en <= 1'b0;
          end else if (rsp_data[31]) begin
            high_cap <= answered & rsp_data[30];
            retried <= 1'b0;
            state <= S_IDENT;
          end else if (over) begin
            state <= S_IDLE; error <= 1'b1; clk_en <= 1'b0;
          end else begin
            polls <= polls + 1'b1;
            state <= S_APP;
          end
        end
        S_IDENT: begin
          if (good) begin
            cid <= rsp_data; retried <= 1'b0; state <= S_ADDR;
          end else if (!retried) begin
            retried <= 1'b1;
          end else begin
            state <= S_IDLE; error <= 1'b1; clk_en <= 1'b0;
          end
        end
        S_ADDR: begin
          if (good) begin
            rca <= rsp_data[31:16]; clk_fast <= 1'b1; done <= 1'b1; state <= S_DONE;
          end else if (!retried) begin
            retried <= 1'b1;
          end else begin
            state <= S_IDLE; error <= 1'b1; clk_en <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> !cmd_req);

  p_app_prefix_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_idx == 6'd41) |-> $past(cmd_idx) == 6'd55);

  p_poll_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_idx == 6'd55) |-> ($past(cmd_idx) == 6'd8 || $past(cmd_idx) == 6'd41));

  p_fast_late_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_fast) |-> $past(busy && rsp_valid && !rsp_crc_err && cmd_idx == 6'd3));

  p_slow_ident_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> (clk_en && !clk_fast));

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(cid) && $stable(rca) && $stable(high_cap)));

endmodule

// File: tb/sd_init_seq_test.sv
module sd_init_seq_test;
  localparam int PRE = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] poll_limit = 16'd8;
  logic cmd_req; logic [5:0] cmd_idx; logic [31:0] cmd_arg; logic [1:0] cmd_rsp_kind;
  logic rsp_valid = 1'b0, rsp_timeout = 1'b0, rsp_crc_err = 1'b0;
  logic [127:0] rsp_data = '0;
  logic clk_en, clk_fast, done, error, high_cap;
  logic [127:0] cid; logic [15:0] rca;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sd_init_seq #(.PREAMBLE_CLKS(PRE), .POLL_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_limit(poll_limit),
    .cmd_req(cmd_req), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_rsp_kind(cmd_rsp_kind),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_crc_err(rsp_crc_err),
    .rsp_data(rsp_data), .clk_en(clk_en), .clk_fast(clk_fast), .done(done),
    .error(error), .high_cap(high_cap), .cid(cid), .rca(rca));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_req(output int en_cycles);
    en_cycles = 0;
    for (int i = 0; i < 500 && !cmd_req; i++) begin
      if (clk_en) en_cycles++;
      @(negedge clk);
    end
  endtask

  task automatic expect_cmd(input logic [5:0] idx, input logic [31:0] arg,
                            input logic [1:0] kind, input string req);
    int n;
    wait_req(n);
    chk(cmd_req == 1'b1, req, "request seen", cmd_req, 1);
    chk(cmd_idx == idx, req, "index", cmd_idx, idx);
    chk(cmd_arg == arg, req, "argument", cmd_arg, arg);
    chk(cmd_rsp_kind == kind, req, "response kind", cmd_rsp_kind, kind);
    chk(clk_fast == 1'b0, "R11", "slow clock during request", clk_fast, 0);
  endtask

  task automatic reply(input bit v, input bit to, input bit crc, input logic [127:0] d);
    @(negedge clk);
    rsp_valid = v; rsp_timeout = to; rsp_crc_err = crc; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_timeout = 1'b0; rsp_crc_err = 1'b0; rsp_data = '0;
  endtask

  task automatic check_aborted(input string req);
    chk(error == 1'b1, req, "error set", error, 1);
    chk(clk_en == 1'b0, req, "clock stopped", clk_en, 0);
    chk(done == 1'b0, req, "not done", done, 0);
    begin
      bit any = 1'b0;
      for (int i = 0; i < 12; i++) begin @(negedge clk); if (cmd_req) any = 1'b1; end
      chk(!any, req, "no request after abort", any, 0);
    end
  endtask

  task automatic t_reset();
    chk(cmd_req == 0 && clk_en == 0 && clk_fast == 0, "R1", "control idle",
        {cmd_req, clk_en, clk_fast}, 0);
    chk(done == 0 && error == 0 && high_cap == 0, "R1", "flags clear", {done, error, high_cap}, 0);
    chk(cid == 0 && rca == 0, "R1", "results clear", {cid[15:0], rca}, 0);
  endtask

  task automatic t_high_capacity();
    int n;
    poll_limit = 16'd8;
    pulse_start();
    wait_req(n);
    chk(n == PRE, "R2", "preamble cycles", n, PRE);
    expect_cmd(6'd0, 32'h0, 2'd0, "R2");
    reply(1, 0, 0, '0);
    expect_cmd(6'd8, 32'h1AA, 2'd1, "R3");
    reply(1, 0, 0, 128'h1AA);
    for (int k = 0; k < 3; k++) begin
      expect_cmd(6'd55, 32'h0, 2'd1, "R4");
      reply(1, 0, 0, '0);
      expect_cmd(6'd41, 32'h40FF_8000, 2'd1, "R5");
      if (k < 2) reply(1, 0, k == 1, 128'h40FF_8000);
      else reply(1, 0, 1, 128'hC0FF_8000);
    end
    chk(high_cap == 1'b1, "R7", "high capacity set", high_cap, 1);
    expect_cmd(6'd2, 32'h0, 2'd2, "R9");
    reply(1, 0, 0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211);
    expect_cmd(6'd3, 32'h0, 2'd1, "R9");
    reply(1, 0, 0, 128'hBEEF_0500);
    chk(done == 1'b1 && error == 1'b0, "R11", "done after address", {done, error}, 2);
    chk(clk_fast == 1'b1 && clk_en == 1'b1, "R11", "fast clock on", {clk_fast, clk_en}, 3);
    chk(cid == 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211, "R9", "cid",
        cid, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211);
    chk(rca == 16'hBEEF, "R9", "rca", rca, 16'hBEEF);
  endtask

  task automatic t_standard_with_retries();
    pulse_start();
    chk(done == 0 && clk_fast == 0 && cid == 0 && rca == 0 && high_cap == 0, "R12",
        "restart clears results", {done, clk_fast, high_cap, rca}, 0);
    expect_cmd(6'd0, 32'h0, 2'd0, "R2");
    reply(1, 0, 0, '0);
    expect_cmd(6'd8, 32'h1AA, 2'd1, "R3");
    reply(0, 1, 0, '0);
    expect_cmd(6'd55, 32'h0, 2'd1, "R4");
    reply(1, 0, 0, '0);
    expect_cmd(6'd41, 32'h00FF_8000, 2'd1, "R5");
    reply(1, 0, 0, 128'hC0FF_8000);
    chk(high_cap == 1'b0, "R7", "no high capacity without probe answer", high_cap, 0);
    expect_cmd(6'd2, 32'h0, 2'd2, "R10");
    reply(1, 0, 1, 128'h5);
    expect_cmd(6'd2, 32'h0, 2'd2, "R10");
    reply(1, 0, 0, 128'hAA55);
    expect_cmd(6'd3, 32'h0, 2'd1, "R10");
    reply(0, 1, 0, '0);
    expect_cmd(6'd3, 32'h0, 2'd1, "R10");
    reply(1, 0, 0, 128'h1234_0000);
    chk(done == 1'b1 && rca == 16'h1234 && cid == 128'hAA55, "R10", "recovered after one retry",
        {done, rca}, {1'b1, 16'h1234});
  endtask

  task automatic t_poll_limit();
    poll_limit = 16'd3;
    pulse_start();
    expect_cmd(6'd0, 32'h0, 2'd0, "R8"); reply(1, 0, 0, '0);
    expect_cmd(6'd8, 32'h1AA, 2'd1, "R8"); reply(1, 0, 0, 128'h1AA);
    for (int k = 0; k < 3; k++) begin
      expect_cmd(6'd55, 32'h0, 2'd1, "R6"); reply(1, 0, 0, '0);
      expect_cmd(6'd41, 32'h40FF_8000, 2'd1, "R6"); reply(1, 0, 0, 128'h0);
    end
    check_aborted("R8");
    poll_limit = 16'd8;
  endtask

  task automatic t_addr_double_fail();
    pulse_start();
    expect_cmd(6'd0, 32'h0, 2'd0, "R10"); reply(1, 0, 0, '0);
    expect_cmd(6'd8, 32'h1AA, 2'd1, "R10"); reply(1, 0, 0, 128'h1AA);
    expect_cmd(6'd55, 32'h0, 2'd1, "R10"); reply(1, 0, 0, '0);
    expect_cmd(6'd41, 32'h40FF_8000, 2'd1, "R10"); reply(1, 0, 0, 128'h8000_0000);
    expect_cmd(6'd2, 32'h0, 2'd2, "R10"); reply(1, 0, 0, 128'h77);
    expect_cmd(6'd3, 32'h0, 2'd1, "R10"); reply(1, 0, 1, 128'h0);
    expect_cmd(6'd3, 32'h0, 2'd1, "R10"); reply(0, 1, 0, 128'h0);
    check_aborted("R10");
  endtask

  task automatic t_bad_echo();
    pulse_start();
    expect_cmd(6'd0, 32'h0, 2'd0, "R3"); reply(1, 0, 0, '0);
    expect_cmd(6'd8, 32'h1AA, 2'd1, "R3"); reply(1, 0, 0, 128'h1A5);
    check_aborted("R3");
  endtask

  task automatic t_app_timeout();
    pulse_start();
    expect_cmd(6'd0, 32'h0, 2'd0, "R8"); reply(1, 0, 0, '0);
    expect_cmd(6'd8, 32'h1AA, 2'd1, "R8"); reply(0, 1, 0, '0);
    expect_cmd(6'd55, 32'h0, 2'd1, "R8"); reply(0, 1, 0, '0);
    check_aborted("R8");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_high_capacity();
        t_standard_with_retries();
        t_poll_limit();
        t_addr_double_fail();
        t_bad_echo();
        t_app_timeout();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule